// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM

This block is a true dual-port static memory of 18-bit words, each word made of two independent 9-bit byte lanes. Both ports share one storage array and one clock; each port has its own address, write data, chip enables, lane selects, read/write control and output enable. Everything except the output enable is captured on the rising clock edge. A write takes effect in that edge. A read returns the word held before any write made in the same edge.

Each port has a static mode input that picks its read path. In flow-through mode the word read at an edge appears after that same edge. In pipelined mode an extra output register holds it back one more cycle. Each port returns its read data together with one drive flag per lane. These flags stand in for tristate pad enables. A lane that is not driven reads as zero on the data bus.

The chip-enable decision takes two register stages in pipelined mode and one in flow-through mode. The lane selects always pass through a single stage. The output enable gates the drive flags without any register.

Top module: `dual_lane_ram`

## Requirements
- R1: While reset is low, and after it until a selected read has been captured, no lane of either port is driven.
- R2: A port is selected only when its cs0_n is 0 and its cs1 is 1. An edge that sees any other combination writes nothing and causes no lane to drive.
- R3: Lane select bit 0 (active low) governs data bits 8:0 and bit 1 governs bits 17:9. A write changes only the lanes whose select is 0.
- R4: rnw = 0 on a selected port writes, and rnw = 1 reads. The output slot belonging to a write edge drives no lane.
- R5: In flow-through mode, data and drive flags for a read captured at edge k are present from just after edge k until edge k+1.
- R6: In pipelined mode, the same read appears one edge later: from edge k+1 until edge k+2.
- R7: In both modes, the drive flag of a lane after edge j is allowed only when that lane's select was 0 at edge j.
- R8: In pipelined mode, a deselect at edge k blocks driving only after edge k+1. The output after edge k still reflects the access of edge k-1.
- R9: oe_n = 1 forces both drive flags of its port to 0 at once, in the same cycle, with no clock edge needed.
- R10: When one port writes an address and the other reads it at the same edge, the read returns the old word. The new word is read from the next edge on.
- R11: When both ports write the same lane of the same address at the same edge, port B's value is stored.
- R12: The data bits of any lane whose drive flag is 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| a_pipe | input | 1 | Port A read path: 1 pipelined, 0 flow-through (static) |
| a_cs0_n | input | 1 | Port A chip enable, active low |
| a_cs1 | input | 1 | Port A chip enable, active high |
| a_rnw | input | 1 | Port A: 1 read, 0 write |
| a_lane_n | input | 2 | Port A lane selects, active low; bit 1 upper lane, bit 0 lower lane |
| a_oe_n | input | 1 | Port A output enable, active low, not registered |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 18 | Port A write data |
| a_rdata | output | 18 | Port A read data, undriven lanes zero |
| a_drive | output | 2 | Port A per-lane drive flags |
| b_pipe | input | 1 | Port B read path: 1 pipelined, 0 flow-through (static) |
| b_cs0_n | input | 1 | Port B chip enable, active low |
| b_cs1 | input | 1 | Port B chip enable, active high |
| b_rnw | input | 1 | Port B: 1 read, 0 write |
| b_lane_n | input | 2 | Port B lane selects, active low; bit 1 upper lane, bit 0 lower lane |
| b_oe_n | input | 1 | Port B output enable, active low, not registered |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 18 | Port B write data |
| b_rdata | output | 18 | Port B read data, undriven lanes zero |
| b_drive | output | 2 | Port B per-lane drive flags |

## Verification
The assertions assume that the mode input of a port stays constant while reset is high, because their latency windows differ by mode. The stimulus changes a mode only while reset is held low. The memory content is unknown at power-up, so the stimulus first fills the addresses it uses and reads nothing else. The output enable is the one input that changes in the middle of a cycle. Its effect is checked at that point, and it is put back before the next edge.

// File: rtl/dual_lane_ram.sv
module dual_lane_ram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  a_pipe,
  input  logic                  a_cs0_n,
  input  logic                  a_cs1,
  input  logic                  a_rnw,
  input  logic [1:0]            a_lane_n,
  input  logic                  a_oe_n,
  input  logic [ADDR_W-1:0]     a_addr,
  input  logic [2*LANE_W-1:0]   a_wdata,
  output logic [2*LANE_W-1:0]   a_rdata,
  output logic [1:0]            a_drive,
  input  logic                  b_pipe,
  input  logic                  b_cs0_n,
  input  logic                  b_cs1,
  input  logic                  b_rnw,
  input  logic [1:0]            b_lane_n,
  input  logic                  b_oe_n,
  input  logic [ADDR_W-1:0]     b_addr,
  input  logic [2*LANE_W-1:0]   b_wdata,
  output logic [2*LANE_W-1:0]   b_rdata,
  output logic [1:0]            b_drive
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 2 * LANE_W;

  logic              pipe  [2];
  logic              sel   [2];
  logic              rnw   [2];
  logic              oe_n  [2];
  logic [1:0]        lane  [2];
  logic [ADDR_W-1:0] addr  [2];
  logic [WORD_W-1:0] wdata [2];
  logic [1:0]        wen   [2];
  logic [WORD_W-1:0] rdata [2];
  logic [1:0]        drive [2];

  assign pipe[0]  = a_pipe;
  assign pipe[1]  = b_pipe;
  assign sel[0]   = ~a_cs0_n & a_cs1;
  assign sel[1]   = ~b_cs0_n & b_cs1;
  assign rnw[0]   = a_rnw;
  assign rnw[1]   = b_rnw;
  assign oe_n[0]  = a_oe_n;
  assign oe_n[1]  = b_oe_n;
  assign lane[0]  = ~a_lane_n;
  assign lane[1]  = ~b_lane_n;
  assign addr[0]  = a_addr;
  assign addr[1]  = b_addr;
  assign wdata[0] = a_wdata;
  assign wdata[1] = b_wdata;

  assign a_rdata = rdata[0];
  assign a_drive = drive[0];
  assign b_rdata = rdata[1];
  assign b_drive = drive[1];

  // one array per lane; port B is applied last so it wins a same-edge clash (R11)
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q   [2];

    always_ff @(posedge clk) begin
      for (int p = 0; p < 2; p++) begin
        q[p] <= mem[addr[p]];
        if (wen[p][l]) mem[addr[p]] <= wdata[p][l*LANE_W +: LANE_W];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic              sel1, sel2, rd1, rd2, en;
    logic [1:0]        lane1;
    logic [WORD_W-1:0] d1, d2, dsel;

    assign wen[p] = (sel[p] & ~rnw[p]) ? lane[p] : 2'b00;
    assign d1     = {g_lane[1].q[p], g_lane[0].q[p]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel1  <= 1'b0;
        sel2  <= 1'b0;
        rd1   <= 1'b0;
        rd2   <= 1'b0;
        lane1 <= 2'b00;
      end else begin
        sel1  <= sel[p];
        sel2  <= sel1;
        rd1   <= rnw[p];
        rd2   <= rd1;
        lane1 <= lane[p];
      end
    end

    always_ff @(posedge clk) d2 <= d1;

    assign en       = pipe[p] ? (sel2 & rd2) : (sel1 & rd1);
    assign drive[p] = (en & ~oe_n[p]) ? lane1 : 2'b00;
    assign dsel     = pipe[p] ? d2 : d1;
    assign rdata[p] = dsel & {{LANE_W{drive[p][1]}}, {LANE_W{drive[p][0]}}};
  end
endmodule

// File: rtl/dual_lane_ram_chk.sv
module dual_lane_ram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       a_pipe,
  input logic       a_cs0_n,
  input logic       a_cs1,
  input logic       a_rnw,
  input logic [1:0] a_lane_n,
  input logic       a_oe_n,
  input logic [1:0] a_drive,
  input logic [1:0] b_lane_n,
  input logic [1:0] b_drive
);
  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe_n |-> (a_drive == 2'b00));

  p_desel_ft_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_pipe && !(!a_cs0_n && a_cs1)) |=> (a_drive == 2'b00));

  p_desel_pl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_pipe && !(!a_cs0_n && a_cs1)) |=> ##1 (a_drive == 2'b00));

  p_write_ft_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_pipe && !a_rnw) |=> (a_drive == 2'b00));

  p_write_pl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_pipe && !a_rnw) |=> ##1 (a_drive == 2'b00));

  p_lane_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_lane_n[0] |=> !a_drive[0]);

  p_lane_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    b_lane_n[1] |=> !b_drive[1]);
endmodule

bind dual_lane_ram dual_lane_ram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a_pipe(a_pipe), .a_cs0_n(a_cs0_n), .a_cs1(a_cs1),
  .a_rnw(a_rnw), .a_lane_n(a_lane_n), .a_oe_n(a_oe_n), .a_drive(a_drive),
  .b_lane_n(b_lane_n), .b_drive(b_drive)
);

// File: tb/sim_dual_lane_ram.sv
module sim_dual_lane_ram;
  localparam int AW = 10;
  localparam int LW = 9;
  localparam int WW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          pipe  [2];
  logic          cs0_n [2];
  logic          cs1   [2];
  logic          rnw   [2];
  logic          oe_n  [2];
  logic [1:0]    lane_n[2];
  logic [AW-1:0] addr  [2];
  logic [WW-1:0] wdata [2];
  logic [WW-1:0] rdata [2];
  logic [1:0]    drive [2];

  dual_lane_ram #(.ADDR_W(AW), .LANE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_pipe(pipe[0]), .a_cs0_n(cs0_n[0]), .a_cs1(cs1[0]), .a_rnw(rnw[0]),
    .a_lane_n(lane_n[0]), .a_oe_n(oe_n[0]), .a_addr(addr[0]), .a_wdata(wdata[0]),
    .a_rdata(rdata[0]), .a_drive(drive[0]),
    .b_pipe(pipe[1]), .b_cs0_n(cs0_n[1]), .b_cs1(cs1[1]), .b_rnw(rnw[1]),
    .b_lane_n(lane_n[1]), .b_oe_n(oe_n[1]), .b_addr(addr[1]), .b_wdata(wdata[1]),
    .b_rdata(rdata[1]), .b_drive(drive[1])
  );

  always #10 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  string tag   = "R1";

  logic [WW-1:0] mm [64];
  bit            e1_sel[2], e1_rd[2], e2_sel[2], e2_rd[2];
  bit [1:0]      e1_ln [2];
  logic [WW-1:0] e1_d  [2], e2_d[2];

  task automatic clear_model();
    for (int p = 0; p < 2; p++) begin
      e1_sel[p] = 0; e1_rd[p] = 0; e2_sel[p] = 0; e2_rd[p] = 0; e1_ln[p] = 2'b00;
      e1_d[p] = '0; e2_d[p] = '0;
    end
  endtask

  task automatic model_edge();
    logic [WW-1:0] nd [2];
    for (int p = 0; p < 2; p++) nd[p] = mm[addr[p][5:0]];
    for (int p = 0; p < 2; p++)
      if (!cs0_n[p] && cs1[p] && !rnw[p]) begin
        if (!lane_n[p][0]) mm[addr[p][5:0]][8:0]  = wdata[p][8:0];
        if (!lane_n[p][1]) mm[addr[p][5:0]][17:9] = wdata[p][17:9];
      end
    for (int p = 0; p < 2; p++) begin
      e2_sel[p] = e1_sel[p]; e2_rd[p] = e1_rd[p]; e2_d[p] = e1_d[p];
      e1_sel[p] = !cs0_n[p] && cs1[p];
      e1_rd[p]  = rnw[p];
      e1_ln[p]  = ~lane_n[p];
      e1_d[p]   = nd[p];
    end
  endtask

  task automatic compare();
    for (int p = 0; p < 2; p++) begin
      bit            en;
      logic [1:0]    ed;
      logic [WW-1:0] exd;
      en  = pipe[p] ? (e2_sel[p] && e2_rd[p]) : (e1_sel[p] && e1_rd[p]);
      ed  = (en && !oe_n[p]) ? e1_ln[p] : 2'b00;
      exd = (pipe[p] ? e2_d[p] : e1_d[p]) & {{LW{ed[1]}}, {LW{ed[0]}}};
      total++;
      if (drive[p] !== ed || rdata[p] !== exd) begin
        bad++;
        $display("FAIL %s port%0d drive act=%b exp=%b data act=%h exp=%h",
                 tag, p, drive[p], ed, rdata[p], exd);
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge(); else clear_model();
    @(negedge clk);
    compare();
  endtask

  task automatic desel(input int p);
    cs0_n[p] = 1; cs1[p] = 0; rnw[p] = 1; lane_n[p] = 2'b11; oe_n[p] = 0;
    addr[p] = '0; wdata[p] = '0;
  endtask

  task automatic idle();
    desel(0); desel(1); step();
  endtask

  task automatic op(input int p, input bit wr, input int a, input logic [1:0] ln,
                    input logic [WW-1:0] d);
    cs0_n[p] = 0; cs1[p] = 1; rnw[p] = !wr; lane_n[p] = ln; oe_n[p] = 0;
    addr[p] = AW'(a); wdata[p] = d;
  endtask

  task automatic run_suite(input bit pl);
    tag = "R4";
    for (int a = 0; a < 64; a++) begin
      op(0, 1, a, 2'b00, WW'(a * 1237 + (pl ? 901 : 55)));
      desel(1);
      step();
    end
    tag = pl ? "R6" : "R5";
    for (int a = 0; a < 64; a++) begin
      op(0, 0, a, 2'b00, '0);
      op(1, 0, 63 - a, 2'b00, '0);
      step();
    end
    idle(); idle();

    tag = "R3";
    op(0, 1, 5, 2'b10, 18'h3ffff); desel(1); step();
    op(0, 1, 6, 2'b01, 18'h00000); step();
    op(0, 0, 5, 2'b00, '0); op(1, 0, 6, 2'b00, '0); step();
    idle(); idle();

    tag = "R12";
    op(0, 0, 7, 2'b10, '0); op(1, 0, 7, 2'b01, '0); step();
    idle(); idle();

    tag = "R2";
    op(0, 1, 8, 2'b00, 18'h15555); cs0_n[0] = 1; cs1[0] = 1; desel(1); step();
    op(0, 1, 9, 2'b00, 18'h2aaaa); cs0_n[0] = 0; cs1[0] = 0; step();
    op(0, 1, 8, 2'b00, 18'h01234); cs0_n[0] = 1; cs1[0] = 0; step();
    op(0, 0, 8, 2'b00, '0); op(1, 0, 9, 2'b00, '0); step();
    idle(); idle();

    tag = pl ? "R8" : "R2";
    op(0, 0, 10, 2'b00, '0); desel(1); step();
    desel(0); step();
    op(0, 0, 11, 2'b00, '0); step();
    desel(0); step();
    idle(); idle();

    tag = "R10";
    op(0, 1, 12, 2'b00, 18'h0beef); op(1, 0, 12, 2'b00, '0); step();
    desel(0); op(1, 0, 12, 2'b00, '0); step();
    idle(); idle();

    tag = "R11";
    op(0, 1, 13, 2'b00, 18'h11111); op(1, 1, 13, 2'b00, 18'h22222); step();
    op(0, 0, 13, 2'b00, '0); desel(1); step();
    idle(); idle();

    tag = "R7";
    op(0, 0, 14, 2'b00, '0); op(1, 0, 15, 2'b11, '0); step();
    op(0, 0, 15, 2'b01, '0); op(1, 0, 14, 2'b00, '0); step();
    op(0, 0, 16, 2'b10, '0); op(1, 0, 16, 2'b01, '0); step();
    idle(); idle();

    tag = "R9";
    op(0, 0, 17, 2'b00, '0); op(1, 0, 18, 2'b00, '0); step();
    step(); step();
    #5 oe_n[0] = 1; oe_n[1] = 1;
    #1 compare();
    oe_n[0] = 0; oe_n[1] = 0;
    #1 compare();
    idle(); idle();

    tag = pl ? "R6" : "R5";
    for (int i = 0; i < 400; i++) begin
      for (int p = 0; p < 2; p++) begin
        int r;
        r = $urandom % 8;
        op(p, ($urandom % 4) == 0, $urandom % 64, 2'($urandom), 18'($urandom));
        if (r == 0) cs0_n[p] = 1;
        if (r == 1) cs1[p] = 0;
        oe_n[p] = ($urandom % 8) == 0;
      end
      step();
    end
    idle(); idle();
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin pipe[p] = 0; desel(p); end
    @(negedge clk);
    tag = "R1";
    repeat (3) step();
    rst_n = 1;
    step(); step();
    run_suite(0);

    rst_n = 0;
    pipe[0] = 1; pipe[1] = 1;
    tag = "R1";
    repeat (3) step();
    rst_n = 1;
    step(); step();
    run_suite(1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule